// File: doc/BRIEF.md
# Port-Sizing Transfer Acknowledge Generator

This slave-side block sits between a 64-bit system bus and a memory whose data port may be narrower. Each transfer the bus hands over is split into port-width data beats. The block drives a data-valid strobe on every beat that crosses the port. It raises a separate termination acknowledge only on the beat that completes a bus-level unit. A bus master therefore sees a clean end of each unit, while the port-side logic sees every individual beat.

A request is a one-cycle start pulse with two more inputs: a transfer kind and a port-width code. There are three kinds: a single 64-bit beat, a pair of double words closed by one termination, and a four-beat burst with one termination per beat. The memory signals progress on a ready input. A stall watchdog ends a transfer abnormally if ready stays low for too long. The block carries no data, generates no addresses and plays no part in arbitration.

Top module: `port_beat_ack`

## Requirements
- R1: Synchronous active-low reset puts the block in idle. A start pulse is accepted only while idle, and the transfer runs from the following cycle.
- R2: `beat_vld_o` is high exactly in running cycles where `mem_rdy_i` is high. No output is ever asserted while idle.
- R3: The width code `port_sel_i` sets the port beats per 64-bit beat: 00 = 64-bit port (1 beat), 01 = 32-bit (2), 10 = 16-bit (4), 11 = 8-bit (8).
- R4: Kind 00 (single) and the spare code 11 move one 64-bit beat. `term_ack_o` is raised once, on its last port beat, and this ends the transfer.
- R5: Kind 10 (burst) moves four 64-bit beats. `term_ack_o` is raised on the last port beat of each of them, and the fourth such assertion ends the transfer.
- R6: Kind 01 (double) moves two 64-bit beats with one termination: 2×ratio port beats, of which only the last carries `term_ack_o`. With a 32-bit port this gives three valid-only cycles followed by one cycle with valid and termination together.
- R7: Whenever `term_ack_o` is high, `beat_vld_o` is high in the same cycle.
- R8: A running cycle with `mem_rdy_i` low asserts no output and does not advance the beat position.
- R9: `xfer_err_o` is raised for one cycle, with neither valid nor termination, on the STALL_LIMIT-th consecutive running cycle with `mem_rdy_i` low. The block is idle in the next cycle. A ready cycle restarts the stall count.
- R10: A start pulse in the cycle of the final termination or of the error is ignored, so the block is idle in the next cycle.
- R11: Kind and width code are captured at the accepted start. Changes to them during a running transfer have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle transfer request |
| kind_i | input | 2 | Transfer kind: 00 single, 01 double, 10 burst, 11 treated as single |
| port_sel_i | input | 2 | Memory port width code (see R3) |
| mem_rdy_i | input | 1 | Memory completes a port beat this cycle |
| beat_vld_o | output | 1 | A port beat moves this cycle |
| term_ack_o | output | 1 | A bus-level unit ends this cycle |
| xfer_err_o | output | 1 | Transfer abandoned after a stall timeout |

## Verification
The bench builds the block with STALL_LIMIT set to 5 and keeps the 64-bit bus, the 8-bit minimum port and four-beat bursts. The short limit brings the timeout, and a stall run that stops one cycle short of it, within reach in a few cycles. The ordinary widths let the bench cover every port width code, including the sixteen-beat double transfer through an 8-bit port.

// File: rtl/pbag_pkg.sv
// Shared types for the port-sizing acknowledge generator.
// Assumes a two-bit kind code on the request side.
package pbag_pkg;

    typedef enum logic [1:0] {
        KIND_SINGLE = 2'b00,
        KIND_DOUBLE = 2'b01,
        KIND_BURST  = 2'b10,
        KIND_SPARE  = 2'b11
    } xfer_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ack_state_e;

endpackage

// File: rtl/pbag_beat_ctr.sv
// Port-beat counter within one terminated segment.
// Counts advancing beats and flags the last beat of the segment.
// Assumes seg_len is nonzero and stays constant between clears.
module pbag_beat_ctr #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             adv,
    input  logic [CNT_W-1:0] seg_len,
    output logic             seg_last
);

    logic [CNT_W-1:0] cnt_q;

    // Last-beat flag: position equals segment length minus one.
    always_comb seg_last = (cnt_q == (seg_len - 1'b1));

    // Beat position: wraps to zero after the last beat of a segment.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clear)      cnt_q <= '0;
        else if (adv)        cnt_q <= seg_last ? '0 : cnt_q + 1'b1;
    end

    // R3
    beat_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (cnt_q < seg_len));

endmodule

// File: rtl/pbag_seg_ctr.sv
// Segment counter: counts terminations within a transfer.
// Flags the final segment, whose termination ends the transfer.
// Assumes seg_total is nonzero and stays constant between clears.
module pbag_seg_ctr #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             adv,
    input  logic [CNT_W-1:0] seg_total,
    output logic             xfer_last
);

    logic [CNT_W-1:0] cnt_q;

    // Final-segment flag.
    always_comb xfer_last = (cnt_q == (seg_total - 1'b1));

    // Segment index: advances on each termination.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clear)      cnt_q <= '0;
        else if (adv)        cnt_q <= xfer_last ? '0 : cnt_q + 1'b1;
    end

    // R5
    seg_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (cnt_q < seg_total));

endmodule

// File: rtl/pbag_stall_wd.sv
// Stall watchdog: counts consecutive active cycles without ready.
// Raises expire on the LIMIT-th such cycle; the count restarts on any
// ready cycle, when inactive, on clear, or after expiring.
// Assumes LIMIT >= 2.
module pbag_stall_wd #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic active,
    input  logic rdy,
    output logic expire
);

    localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LIM_M1 = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Timeout flag on the final stalled cycle.
    always_comb expire = active && !rdy && (cnt_q == LIM_M1);

    // Stall run length.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     cnt_q <= '0;
        else if (clear || !active || rdy || expire)     cnt_q <= '0;
        else                                            cnt_q <= cnt_q + 1'b1;
    end

    // R9
    stall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM_M1);

    // R9
    expire_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == '0));

endmodule

// File: rtl/port_beat_ack.sv
// Port-sizing transfer acknowledge generator (top).
// Splits each accepted bus transfer into port-width beats, strobing
// beat_vld_o per beat and term_ack_o at each bus-level unit end.
// A stall watchdog ends a hung transfer with xfer_err_o.
// Assumes BUS_W / MIN_PORT_W is a power of two and mem_rdy_i is
// synchronous to clk. Outputs are combinational from mem_rdy_i.
module port_beat_ack #(
    parameter int BUS_W       = 64,
    parameter int MIN_PORT_W  = 8,
    parameter int BURST_BEATS = 4,
    parameter int STALL_LIMIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] kind_i,
    input  logic [1:0] port_sel_i,
    input  logic       mem_rdy_i,
    output logic       beat_vld_o,
    output logic       term_ack_o,
    output logic       xfer_err_o
);
    import pbag_pkg::*;

    localparam int MAX_RATIO = BUS_W / MIN_PORT_W;
    localparam int SEG_MAX   = 2 * MAX_RATIO;
    localparam int BEAT_W    = $clog2(SEG_MAX + 1);
    localparam int SEGCNT_W  = $clog2(BURST_BEATS + 1);

    ack_state_e       state_q;
    xfer_kind_e       kind_q;
    logic [1:0]       sel_q;
    logic             accept, run, adv, seg_last, xfer_last;
    logic             term, done, expire;
    logic [BEAT_W-1:0]   ratio, seg_len;
    logic [SEGCNT_W-1:0] seg_total;

    // Request acceptance and per-cycle beat decode.
    always_comb begin
        accept = (state_q == ST_IDLE) && start_i;
        run    = (state_q == ST_RUN);
        adv    = run && mem_rdy_i;
        term   = adv && seg_last;
        done   = term && xfer_last;
    end

    // Segment shape from the captured kind and width code.
    always_comb begin
        ratio     = BEAT_W'(1) << sel_q;
        seg_len   = (kind_q == KIND_DOUBLE) ? (ratio << 1) : ratio;
        seg_total = (kind_q == KIND_BURST) ? SEGCNT_W'(BURST_BEATS) : SEGCNT_W'(1);
    end

    // Control state: idle until accepted, run until final term or error.
    always_ff @(posedge clk) begin
        if (!rst_n)                         state_q <= ST_IDLE;
        else if (accept)                    state_q <= ST_RUN;
        else if (run && (done || expire))   state_q <= ST_IDLE;
    end

    // Request capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= KIND_SINGLE;
            sel_q  <= 2'b00;
        end else if (accept) begin
            kind_q <= xfer_kind_e'(kind_i);
            sel_q  <= port_sel_i;
        end
    end

    pbag_beat_ctr #(.CNT_W(BEAT_W)) u_beat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .adv      (adv),
        .seg_len  (seg_len),
        .seg_last (seg_last)
    );

    pbag_seg_ctr #(.CNT_W(SEGCNT_W)) u_seg (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .adv       (term),
        .seg_total (seg_total),
        .xfer_last (xfer_last)
    );

    pbag_stall_wd #(.LIMIT(STALL_LIMIT)) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .active (run),
        .rdy    (mem_rdy_i),
        .expire (expire)
    );

    // Output drive.
    always_comb begin
        beat_vld_o = adv;
        term_ack_o = term;
        xfer_err_o = expire;
    end

    // R7
    term_has_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term_ack_o |-> beat_vld_o);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !(beat_vld_o || term_ack_o || xfer_err_o));

    // R8
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rdy_i |-> !(beat_vld_o || term_ack_o));

    // R9
    err_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err_o |=> (state_q == ST_IDLE));

    // R10
    end_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (done || xfer_err_o)) |=> (state_q == ST_IDLE));

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> ($stable(kind_q) && $stable(sel_q)));

endmodule

// File: tb/port_beat_ack_bench.sv
`timescale 1ns/1ps
module port_beat_ack_bench;

    localparam int LIMIT = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] kind_i = 2'b00;
    logic [1:0] port_sel_i = 2'b00;
    logic       mem_rdy_i = 1'b0;
    logic       beat_vld_o, term_ack_o, xfer_err_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  ev;
        logic  et;
        logic  ee;
        string rq;
    } exp_t;
    exp_t expq[$];

    always #2.5 clk = ~clk;

    port_beat_ack #(.STALL_LIMIT(LIMIT)) u_port_beat_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .kind_i     (kind_i),
        .port_sel_i (port_sel_i),
        .mem_rdy_i  (mem_rdy_i),
        .beat_vld_o (beat_vld_o),
        .term_ack_o (term_ack_o),
        .xfer_err_o (xfer_err_o)
    );

    // Driver: apply one cycle of inputs and queue the expected outputs.
    task automatic step(input logic st, input logic [1:0] kd, input logic [1:0] sl,
                        input logic rd, input logic ev, input logic et,
                        input logic ee, input string rq);
        exp_t e;
        @(negedge clk);
        start_i = st; kind_i = kd; port_sel_i = sl; mem_rdy_i = rd;
        e.ev = ev; e.et = et; e.ee = ee; e.rq = rq;
        expq.push_back(e);
    endtask

    // Monitor: compare outputs against the queue mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                checks++;
                if ({beat_vld_o, term_ack_o, xfer_err_o} !== {e.ev, e.et, e.ee}) begin
                    fails++;
                    $display("FAIL %s: vld/term/err = %b%b%b, expected %b%b%b",
                             e.rq, beat_vld_o, term_ack_o, xfer_err_o, e.ev, e.et, e.ee);
                end
            end
        end
    end

    // Reference transfer: kinds 00/11 single, 01 double, 10 burst of four.
    task automatic do_xfer(input logic [1:0] kd, input logic [1:0] sl,
                           input int stall, input bit end_start);
        int ratio, segl, segs;
        string rq;
        ratio = 1 << sl;
        segl  = (kd == 2'b01) ? 2 * ratio : ratio;
        segs  = (kd == 2'b10) ? 4 : 1;
        rq = (kd == 2'b10) ? "R5 R3 R11" : (kd == 2'b01) ? "R6 R3 R11" : "R4 R3 R11";
        step(1'b1, kd, sl, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
        for (int s = 0; s < segs; s++) begin
            for (int b = 0; b < segl; b++) begin
                bit last, fin;
                for (int k = 0; k < stall; k++)
                    step(1'b0, ~kd, ~sl, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
                last = (b == segl - 1);
                fin  = last && (s == segs - 1);
                step(fin && end_start, ~kd, ~sl, 1'b1, 1'b1, last, 1'b0,
                     last ? {rq, " R7"} : {rq, " R2"});
            end
        end
        step(1'b0, kd, sl, 1'b1, 1'b0, 1'b0, 1'b0, "R10");
    endtask

    // Watchdog: a hung run is a failure that still reaches the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset holds the block quiet despite start and ready.
        for (int i = 0; i < 3; i++)
            step(1'b1, 2'b10, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
        @(negedge clk); rst_n = 1'b1;
        start_i = 1'b0; mem_rdy_i = 1'b1;
        // R2: idle with ready high stays quiet.
        step(1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, "R2");

        do_xfer(2'b00, 2'b00, 0, 1'b1);   // single, 64-bit port
        do_xfer(2'b00, 2'b11, 1, 1'b0);   // single, 8-bit port, stalls
        do_xfer(2'b01, 2'b01, 0, 1'b1);   // double, 32-bit: 3 valid then term
        do_xfer(2'b10, 2'b10, 2, 1'b0);   // burst, 16-bit, stalls
        do_xfer(2'b10, 2'b00, 0, 1'b1);   // burst, 64-bit
        do_xfer(2'b11, 2'b01, 0, 1'b0);   // spare code acts as single
        do_xfer(2'b01, 2'b11, 0, 1'b0);   // double, 8-bit: sixteen beats
        do_xfer(2'b10, 2'b00, LIMIT - 1, 1'b1); // R9: stall runs just short of limit

        // R9: stall timeout, with a start in the error cycle (R10).
        step(1'b1, 2'b10, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
        for (int k = 0; k < LIMIT - 1; k++)
            step(1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        step(1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
        step(1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, "R9 R10");
        // After the error, a fresh transfer works normally.
        do_xfer(2'b00, 2'b01, 0, 1'b0);

        @(negedge clk);
        @(negedge clk);
        #3;
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule